// File: doc/BRIEF.md
# Multi-mode timer interrupt flag unit

This block is an 8-bit timer with two channels. Each channel can work as a compare channel or as a capture channel. The timer counts in one of three ways: a full free-running wrap, a modulo count whose top is set by the channel 0 compare value, or an up/down count between zero and that same top.

The block keeps three sticky event flags: one per channel and one for overflow. The event that sets each flag depends on the counting mode and on whether the channel compares or captures. A CPU clears a flag with a per-flag strobe. The block combines the flags with per-flag enables into a single interrupt request pulse. It also sends a one-cycle trigger to a DMA controller each time a channel flag goes from clear to set.

Top module: `tmr_flag_unit`

## Requirements
- R1: With `mode_i` = 0 (free-running; code 3 behaves the same), `count_o` steps by one on every clock and wraps from 0xFF to 0x00.
- R2: With `mode_i` = 1 (modulo), `count_o` counts 0, 1, … up to `cmp0_i` and then returns to 0 on the next clock.
- R3: With `mode_i` = 2 (up/down) and a nonzero `cmp0_i`, `count_o` rises from 0 to `cmp0_i` and then falls back to 0. It turns upward again at 0, so the period is 2·`cmp0_i` clocks.
- R4: In free-running and modulo modes, a compare channel sets its flag when the count equals its compare value. Flag bit 0 belongs to channel 0 and bit 1 to channel 1. Overflow (bit 2) sets when the count holds its terminal value: 0xFF in free-running mode, `cmp0_i` in modulo mode. Each flag becomes visible one clock after the matching count.
- R5: In up/down mode, when channel 0 is in compare, flag bit 0 and overflow bit 2 both set on the turnaround at zero, one clock after the count is 0 on its way down. Channel 1 in compare sets bit 1 when the count equals `cmp1_i` in either direction.
- R6: A channel with its `cap_sel_i` bit set to 1 ignores its compare value. Its `cap_in_i` bit passes through two synchronising flops. On the selected edge (`cap_edge_i` bit 0 = rising, 1 = falling), the channel latches the count into its capture output and sets its flag. Both are visible on the third clock after the input changes. In up/down mode with capture channels, overflow still sets at the zero turnaround.
- R7: A set flag stays set until its `clr_i` bit is pulsed. A `clr_i` bit affects only its own flag. When a clear and a setting event arrive in the same clock, the flag stays set.
- R8: `dma_o[i]` is high for exactly one clock, in the first clock that flag bit i is set. While the flag stays set, further events on that channel give no new trigger.
- R9: `irq_o` is a one-clock request pulse. It fires when some flag that is enabled by `mask_i` (same bit positions as the flags) becomes set. It also fires one clock after a mask bit is raised while its flag is already pending. An event on a flag that is already set raises no new request.
- R10: During and right after reset, the count, flags, triggers, request and capture outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Counting mode: 0 free-running, 1 modulo, 2 up/down, 3 as free-running |
| cap_sel_i | input | 2 | Per channel: 1 = capture, 0 = compare |
| cap_edge_i | input | 2 | Per channel capture edge: 0 rising, 1 falling |
| cap_in_i | input | 2 | Asynchronous capture inputs, one per channel |
| cmp0_i | input | 8 | Channel 0 compare value; also the top for modulo and up/down |
| cmp1_i | input | 8 | Channel 1 compare value |
| mask_i | input | 3 | Request enables: bit 0 ch0, bit 1 ch1, bit 2 overflow |
| clr_i | input | 3 | Flag clear strobes, same bit positions |
| count_o | output | 8 | Current count |
| flag_o | output | 3 | Sticky flags: bit 0 ch0, bit 1 ch1, bit 2 overflow |
| irq_o | output | 1 | One-clock interrupt request pulse |
| dma_o | output | 2 | One-clock DMA triggers for channel 0 and 1 |
| cap0_o | output | 8 | Channel 0 captured count |
| cap1_o | output | 8 | Channel 1 captured count |

## Verification
The bench counts clock edges from the release of reset. After edge n the count is a closed-form function of n and the mode. A compare or overflow event raised by the count held before edge k shows up in the flags, the DMA triggers and the request after edge k+1. A capture shows up on the third edge after the input moves. A mask enable or a clear takes effect on the next edge. All outputs are sampled at the falling edge that follows the edge where each result is due, so every check lands exactly on its due cycle and never one edge early or late. Compare-mode sweeps keep every clear strobe asserted, so each event appears as its own one-clock flag and can be matched edge by edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the multi-mode timer flag unit.
// Assumes two channels and three flags (two channel flags plus overflow).
package tmr_pkg;
    typedef enum logic [1:0] {
        TM_FREE   = 2'd0,
        TM_MODULO = 2'd1,
        TM_UPDOWN = 2'd2
    } tm_mode_e;

    localparam int N_CH    = 2;
    localparam int NUM_FLG = 3;
    localparam int FLG_CH0 = 0;
    localparam int FLG_CH1 = 1;
    localparam int FLG_OVF = 2;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Counter core: free-running wrap, modulo to top_i, or up/down between 0 and top_i.
// Reports the terminal-count cycle (free/modulo) and the zero turnaround (up/down).
// Assumes an undefined mode code acts as free-running. In up/down mode a top
// value of zero holds the count at zero and raises no turnaround.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         tc_o,
    output logic         zero_o
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    tm_mode_e     mode;
    logic [W-1:0] cnt_q, cnt_n;
    logic         up_q, up_n;

    assign mode  = tm_mode_e'(mode_i);
    assign cnt_o = cnt_q;

    // Next-count, direction and event decode for the current mode.
    always_comb begin
        cnt_n  = cnt_q + ONE;
        up_n   = 1'b1;
        tc_o   = 1'b0;
        zero_o = 1'b0;
        case (mode)
            TM_MODULO: begin
                tc_o = (cnt_q >= top_i);
                if (tc_o) cnt_n = '0;
            end
            TM_UPDOWN: begin
                up_n = up_q;
                if (top_i == '0) begin
                    cnt_n = '0;
                end else if (up_q) begin
                    if (cnt_q >= top_i) begin
                        up_n  = 1'b0;
                        cnt_n = cnt_q - ONE;
                    end
                end else if (cnt_q == '0) begin
                    zero_o = 1'b1;
                    up_n   = 1'b1;
                    cnt_n  = ONE;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
            default: tc_o = (cnt_q == CNT_MAX);
        endcase
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_n;
            up_q  <= up_n;
        end
    end

    // R1
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_FREE) |=> (cnt_q == $past(cnt_q) + ONE));

    // R2
    mod_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_MODULO) && (cnt_q >= top_i) |=> (cnt_q == '0));

    // R3
    ud_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_UPDOWN) && (top_i != '0) && (cnt_q == '0) && !up_q
        |=> (cnt_q == ONE) && up_q);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// One compare/capture channel. The capture input is synchronised through SYNC
// flops and edge-detected. On the selected edge the channel latches the count.
// The compare hit is suppressed while the channel is in capture.
// Assumes SYNC >= 2 and that cap_in_i may be asynchronous to clk.
module tmr_channel #(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_sel_i,
    input  logic         cap_fall_i,
    input  logic         cap_in_i,
    input  logic [W-1:0] cmp_i,
    input  logic [W-1:0] cnt_i,
    output logic         cmp_hit_o,
    output logic         cap_ev_o,
    output logic [W-1:0] cap_o
);
    logic [SYNC-1:0] sync_q;
    logic            last_q;
    logic            s_now;
    logic [W-1:0]    cap_q;

    assign s_now     = sync_q[SYNC-1];
    assign cap_ev_o  = cap_sel_i & (cap_fall_i ? (~s_now & last_q) : (s_now & ~last_q));
    assign cmp_hit_o = !cap_sel_i && (cnt_i == cmp_i);
    assign cap_o     = cap_q;

    // Synchroniser chain and previous-value register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], cap_in_i};
            last_q <= s_now;
        end
    end

    // Capture register loads the count on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (cap_ev_o) cap_q <= cnt_i;
    end

    // R6
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev_o |=> (cap_q == $past(cnt_i)));
endmodule

// File: rtl/tmr_flag_ctrl.sv
`timescale 1ns/1ps
// Sticky flags with set-over-clear priority, a rising-edge DMA trigger on the
// lowest N_TRIG flags, and a one-cycle request pulse raised whenever an enabled
// flag becomes active, either by the flag setting or by its mask rising.
// Assumes N_TRIG <= N.
module tmr_flag_ctrl #(
    parameter int N      = 3,
    parameter int N_TRIG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      set_i,
    input  logic [N-1:0]      clr_i,
    input  logic [N-1:0]      mask_i,
    output logic [N-1:0]      flag_o,
    output logic [N_TRIG-1:0] dma_o,
    output logic              irq_o
);
    logic [N-1:0]      flag_q, mask_q, act_d_q, act;
    logic [N_TRIG-1:0] flag_d_q;

    assign act    = flag_q & mask_q;
    assign flag_o = flag_q;
    assign dma_o  = flag_q[N_TRIG-1:0] & ~flag_d_q;
    assign irq_o  = |(act & ~act_d_q);

    // Flag, mask and history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q   <= '0;
            flag_d_q <= '0;
            mask_q   <= '0;
            act_d_q  <= '0;
        end else begin
            flag_q   <= set_i | (flag_q & ~clr_i);
            flag_d_q <= flag_q[N_TRIG-1:0];
            mask_q   <= mask_i;
            act_d_q  <= act;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_flag_chk
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
        // R7
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[i] && !clr_i[i] |=> flag_q[i]);
    end

    for (genvar j = 0; j < N_TRIG; j++) begin : g_dma_chk
        // R8
        dma_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dma_o[j] |=> !dma_o[j]);
    end

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(flag_q & mask_q)));
endmodule

// File: rtl/tmr_flag_unit.sv
`timescale 1ns/1ps
// Top of the timer flag unit. Routes counter and channel events to the three
// flags according to counting mode and channel mode, and exposes count,
// flags, request, DMA triggers and captured values.
// Assumes cmp0_i also serves as the top for modulo and up/down counting.
module tmr_flag_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic [N_CH-1:0]    cap_sel_i,
    input  logic [N_CH-1:0]    cap_edge_i,
    input  logic [N_CH-1:0]    cap_in_i,
    input  logic [CNT_W-1:0]   cmp0_i,
    input  logic [CNT_W-1:0]   cmp1_i,
    input  logic [NUM_FLG-1:0] mask_i,
    input  logic [NUM_FLG-1:0] clr_i,
    output logic [CNT_W-1:0]   count_o,
    output logic [NUM_FLG-1:0] flag_o,
    output logic               irq_o,
    output logic [N_CH-1:0]    dma_o,
    output logic [CNT_W-1:0]   cap0_o,
    output logic [CNT_W-1:0]   cap1_o
);
    logic [CNT_W-1:0]   cnt;
    logic               cnt_tc, cnt_zero, is_ud;
    logic [CNT_W-1:0]   cmp_arr [N_CH];
    logic [CNT_W-1:0]   cap_arr [N_CH];
    logic [N_CH-1:0]    cmp_hit, cap_ev;
    logic [NUM_FLG-1:0] set_vec;

    assign cmp_arr[0] = cmp0_i;
    assign cmp_arr[1] = cmp1_i;
    assign cap0_o     = cap_arr[0];
    assign cap1_o     = cap_arr[1];
    assign count_o    = cnt;
    assign is_ud      = (tm_mode_e'(mode_i) == TM_UPDOWN);

    tmr_counter #(.W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .top_i  (cmp0_i),
        .cnt_o  (cnt),
        .tc_o   (cnt_tc),
        .zero_o (cnt_zero)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tmr_channel #(.W(CNT_W), .SYNC(SYNC_N)) u_channel (
            .clk        (clk),
            .rst_n      (rst_n),
            .cap_sel_i  (cap_sel_i[c]),
            .cap_fall_i (cap_edge_i[c]),
            .cap_in_i   (cap_in_i[c]),
            .cmp_i      (cmp_arr[c]),
            .cnt_i      (cnt),
            .cmp_hit_o  (cmp_hit[c]),
            .cap_ev_o   (cap_ev[c]),
            .cap_o      (cap_arr[c])
        );
    end

    // Select the setting event of each flag from mode and channel function.
    always_comb begin
        set_vec[FLG_CH0] = cap_sel_i[0] ? cap_ev[0] : (is_ud ? cnt_zero : cmp_hit[0]);
        set_vec[FLG_CH1] = cap_sel_i[1] ? cap_ev[1] : cmp_hit[1];
        set_vec[FLG_OVF] = is_ud ? cnt_zero : cnt_tc;
    end

    tmr_flag_ctrl #(.N(NUM_FLG), .N_TRIG(N_CH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_i),
        .mask_i (mask_i),
        .flag_o (flag_o),
        .dma_o  (dma_o),
        .irq_o  (irq_o)
    );

    // R5
    ud_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ud && !cap_sel_i[0] && cnt_zero |=> flag_o[FLG_CH0] && flag_o[FLG_OVF]);
endmodule

// File: tb/tmr_flag_unit_bench.sv
`timescale 1ns/1ps
// Self-checking bench: closed-form sweeps of the compare modes plus directed
// tests for stickiness, clear priority, masking and capture.
module tmr_flag_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [1:0] cap_sel_i = 2'b00, cap_edge_i = 2'b00, cap_in_i = 2'b00;
    logic [7:0] cmp0_i = 8'd0, cmp1_i = 8'd0;
    logic [2:0] mask_i = 3'b000, clr_i = 3'b000;
    logic [7:0] count_o, cap0_o, cap1_o;
    logic [2:0] flag_o;
    logic       irq_o;
    logic [1:0] dma_o;

    int total = 0;
    int bad   = 0;
    int n     = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr_flag_unit u_tmr_flag_unit (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cap_sel_i(cap_sel_i),
        .cap_edge_i(cap_edge_i), .cap_in_i(cap_in_i), .cmp0_i(cmp0_i),
        .cmp1_i(cmp1_i), .mask_i(mask_i), .clr_i(clr_i), .count_o(count_o),
        .flag_o(flag_o), .irq_o(irq_o), .dma_o(dma_o), .cap0_o(cap0_o),
        .cap1_o(cap1_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at n=%0d: actual=%0d expected=%0d", tag, n, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        n++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
    endtask

    // Count held after k edges since reset release.
    function automatic int exp_cnt(int md, int top, int k);
        int p;
        if (md == 1) return k % (top + 1);
        if (md == 2) begin
            p = k % (2 * top);
            return (p <= top) ? p : 2 * top - p;
        end
        return k % 256;
    endfunction

    // Events raised by the count held before edge k+1: {ovf, ch1, ch0}.
    function automatic logic [2:0] exp_ev(int md, int top, int c1, int k);
        int  c;
        bit  z;
        if (k < 0) return 3'b000;
        c = exp_cnt(md, top, k);
        if (md == 2) begin
            z = (k > 0) && (k % (2 * top) == 0);
            return {z, c == c1, z};
        end
        if (md == 1) return {c == top, c == c1, c == top};
        return {c == 255, c == c1, c == top};
    endfunction

    task automatic run_cfg(input int md, input int c0, input int c1, input int cycles);
        logic [2:0] f, fd;
        string      ctag, ftag;
        ctag = (md == 0) ? "R1 count" : (md == 1) ? "R2 count" : "R3 count";
        ftag = (md == 2) ? "R5 flags" : "R4 flags";
        mode_i = 2'(md); cmp0_i = 8'(c0); cmp1_i = 8'(c1);
        cap_sel_i = 2'b00; cap_in_i = 2'b00; clr_i = 3'b111; mask_i = 3'b111;
        do_reset();
        for (int k = 1; k <= cycles; k++) begin
            tick();
            f  = exp_ev(md, c0, c1, n - 1);
            fd = exp_ev(md, c0, c1, n - 2);
            chk(ctag, int'(count_o), exp_cnt(md, c0, n));
            chk(ftag, int'(flag_o), int'(f));
            chk("R8 dma", int'(dma_o), int'(f[1:0] & ~fd[1:0]));
            chk("R9 irq", int'(irq_o), int'(|(f & ~fd)));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all R): actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R10: reset state
        do_reset();
        chk("R10 count", int'(count_o), 0);
        chk("R10 flags", int'(flag_o), 0);
        chk("R10 irq", int'(irq_o), 0);
        chk("R10 dma", int'(dma_o), 0);
        chk("R10 cap0", int'(cap0_o), 0);
        chk("R10 cap1", int'(cap1_o), 0);

        // R1, R2, R3, R4, R5, R8, R9 sweeps with clears held on
        run_cfg(0, 0, 3, 530);
        run_cfg(0, 7, 255, 530);
        run_cfg(0, 255, 128, 530);
        run_cfg(1, 1, 0, 60);
        run_cfg(1, 4, 2, 60);
        run_cfg(1, 9, 12, 60);
        run_cfg(2, 1, 0, 60);
        run_cfg(2, 3, 3, 60);
        run_cfg(2, 6, 2, 60);

        // R7 / R8 / R9: sticky flag, set-wins clear, mask re-request
        mode_i = 2'd1; cmp0_i = 8'd3; cmp1_i = 8'd2;
        cap_sel_i = 2'b00; clr_i = 3'b000; mask_i = 3'b010;
        do_reset();
        while (n < 3) tick();
        chk("R4 ch1 flag set", int'(flag_o[1]), 1);
        chk("R8 dma1 pulse", int'(dma_o[1]), 1);
        chk("R9 irq on flag rise", int'(irq_o), 1);
        while (n < 9) begin
            tick();
            chk("R7 ch1 sticky", int'(flag_o[1]), 1);
            chk("R8 no repeat dma1", int'(dma_o[1]), 0);
            chk("R9 no repeat irq", int'(irq_o), 0);
        end
        tick();                          // n=10, count is 2
        chk("R2 count before clash", int'(count_o), 2);
        clr_i = 3'b010;
        tick();                          // n=11: event and clear collided
        chk("R7 set wins", int'(flag_o[1]), 1);
        chk("R8 no dma on clash", int'(dma_o[1]), 0);
        tick();                          // n=12: plain clear
        chk("R7 clear", int'(flag_o[1]), 0);
        chk("R7 clear only own bit", int'(flag_o[0]), 1);
        clr_i = 3'b000;
        mask_i = 3'b000;
        while (n < 15) tick();
        chk("R7 reset after clear", int'(flag_o[1]), 1);
        chk("R9 masked no irq", int'(irq_o), 0);
        tick();                          // n=16
        mask_i = 3'b010;
        tick();                          // n=17
        chk("R9 mask enable request", int'(irq_o), 1);
        tick();
        chk("R9 request is a pulse", int'(irq_o), 0);

        // R6: capture in free-running mode, rising on ch0, falling on ch1
        mode_i = 2'd0; cmp0_i = 8'd2; cmp1_i = 8'd3;
        cap_sel_i = 2'b11; cap_edge_i = 2'b10; cap_in_i = 2'b10;
        clr_i = 3'b000; mask_i = 3'b000;
        do_reset();
        while (n < 5) tick();
        chk("R6 compare and wrong edge ignored", int'(flag_o), 0);
        cap_in_i[0] = 1'b1;
        while (n < 7) tick();
        chk("R6 ch0 not early", int'(flag_o[0]), 0);
        tick();                          // n=8
        chk("R6 ch0 flag", int'(flag_o[0]), 1);
        chk("R6 ch0 value", int'(cap0_o), 7);
        chk("R8 dma0 on capture", int'(dma_o[0]), 1);
        cap_in_i[1] = 1'b0;
        while (n < 10) tick();
        chk("R6 ch1 not early", int'(flag_o[1]), 0);
        tick();                          // n=11
        chk("R6 ch1 falling flag", int'(flag_o[1]), 1);
        chk("R6 ch1 value", int'(cap1_o), 10);

        // R5 / R6: up/down with capture channels
        mode_i = 2'd2; cmp0_i = 8'd4; cmp1_i = 8'd1;
        cap_sel_i = 2'b11; cap_edge_i = 2'b00; cap_in_i = 2'b00;
        do_reset();
        while (n < 8) tick();
        chk("R6 no capture flags yet", int'(flag_o), 0);
        tick();                          // n=9
        chk("R6 ovf only at zero", int'(flag_o), 3'b100);
        cap_in_i[1] = 1'b1;
        while (n < 12) tick();
        chk("R6 ud ch1 capture", int'(flag_o), 3'b110);
        chk("R6 ud ch1 value", int'(cap1_o), 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule